// File: doc/BRIEF.md
# Banked Register Window Decoder

This block owns the byte-wide register space behind a serial configuration port. The 8-bit address splits into two halves. Addresses 00h to 7Fh always reach one shared bank. That bank holds control bytes, the password entry area and the page selector. Addresses 80h to FFh form a window, and the page selector decides which of several pages appears in it. Each page has its own storage.

Each page has a write privilege. Page 01h accepts writes at the first privilege level. Pages 02h to 05h need the second level. Pages above 05h, up to the last one built, accept writes at any level. A grant at the second level also covers the first. Password comparison happens outside the block, and its result arrives as two grant flags. A write without enough privilege changes nothing and latches a sticky refusal flag. If the selector holds a value that names no page, the window reads as all ones and drops writes.

Accesses take one cycle. A request with the write strobe high updates storage on the clock edge. A request with the write strobe low places the addressed byte on the read-data output at that same edge.

Top module: `regpage_map`

## Requirements
- R1: Addresses 00h to 7Fh can be read and written regardless of the grant flags and the selector. A write there never sets the refusal flag.
- R2: A read request loads `rdata` at the clock edge that samples it. `rdata` keeps its value through idle cycles and write cycles.
- R3: The page selector is the byte at lower address 7Fh, and its reset value is 01h. A selector write applies to the very next access.
- R4: Selector values 01h to N_TABLES each map a separate page. The same window offset in two pages holds two independent bytes.
- R5: Writes to page 01h take effect when `pw1_ok` or `pw2_ok` is high. With both flags low they are refused.
- R6: Writes to pages 02h to 05h take effect only when `pw2_ok` is high. `pw1_ok` alone is refused.
- R7: Pages numbered 06h up to N_TABLES accept writes with both grant flags low.
- R8: A refused write leaves the addressed byte unchanged. It sets `wr_denied`, which stays high until reset.
- R9: With a selector of 00h or above N_TABLES, window reads return FFh and window writes change no page. Such writes do not set `wr_denied`.
- R10: Reset clears `rdata`, `wr_denied` and every storage byte except the selector.
- R11: Window reads are never gated by the grant flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | Write strobe; 0 = read |
| addr | input | 8 | Byte address; bit 7 selects the window |
| wdata | input | 8 | Write data |
| pw1_ok | input | 1 | First-level grant from the password check |
| pw2_ok | input | 1 | Second-level grant from the password check |
| rdata | output | 8 | Registered read data |
| wr_denied | output | 1 | Sticky flag for a refused window write |

## Verification
The bench builds the block with its defaults: six pages, the selector at 7Fh and a reset selector of 01h. With these values every privilege class can be reached: the first-level page, the four second-level pages and one open page. The undefined selectors 00h, 07h (just past the last page) and FFh are all reachable too. Each scenario writes page-specific patterns at a common offset, so that aliasing between pages or a wrong privilege class shows up as a wrong byte on readback.

// File: rtl/regpage_pkg.sv
package regpage_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int OFF_W      = ADDR_W - 1;
    localparam int HALF_DEPTH = 1 << OFF_W;

    // Write privilege class of a page
    typedef enum logic [1:0] {
        LVL_OPEN = 2'd0,
        LVL_ONE  = 2'd1,
        LVL_TWO  = 2'd2
    } wr_level_e;

    // Decoded address
    typedef struct packed {
        logic             upper;
        logic [OFF_W-1:0] offset;
    } addr_dec_t;

    // Access request after gating
    typedef struct packed {
        logic lo_we;
        logic up_we;
        logic rd_en;
        logic deny;
    } access_t;

    function automatic wr_level_e table_level(input logic [DATA_W-1:0] sel);
        if (sel == 8'h01)
            return LVL_ONE;
        else if (sel >= 8'h02 && sel <= 8'h05)
            return LVL_TWO;
        else
            return LVL_OPEN;
    endfunction

    function automatic logic level_met(input wr_level_e lvl, input logic pw1, input logic pw2);
        case (lvl)
            LVL_ONE: return pw1 | pw2;
            LVL_TWO: return pw2;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/regpage_decode.sv
module regpage_decode
    import regpage_pkg::*;
#(
    parameter int N_TABLES = 6,
    localparam int IDX_W   = (N_TABLES > 1) ? $clog2(N_TABLES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] sel,
    output addr_dec_t         dec,
    output logic              tbl_valid,
    output logic [IDX_W-1:0]  tbl_idx
);

    always_comb begin
        dec.upper  = addr[ADDR_W-1];
        dec.offset = addr[OFF_W-1:0];
        tbl_valid  = (sel != '0) && (sel <= DATA_W'(N_TABLES));
        tbl_idx    = IDX_W'(sel - DATA_W'(1));
    end

endmodule

// File: rtl/regpage_gate.sv
module regpage_gate
    import regpage_pkg::*;
(
    input  logic              req,
    input  logic              we,
    input  addr_dec_t         dec,
    input  logic              tbl_valid,
    input  logic [DATA_W-1:0] sel,
    input  logic              pw1_ok,
    input  logic              pw2_ok,
    output access_t           acc
);

    wr_level_e lvl;
    logic      allowed;
    logic      up_wr;

    always_comb begin
        lvl       = table_level(sel);
        allowed   = level_met(lvl, pw1_ok, pw2_ok);
        up_wr     = req && we && dec.upper && tbl_valid;
        acc.lo_we = req && we && !dec.upper;
        acc.up_we = up_wr && allowed;
        acc.deny  = up_wr && !allowed;
        acc.rd_en = req && !we;
    end

endmodule

// File: rtl/regpage_store.sv
module regpage_store
    import regpage_pkg::*;
#(
    parameter int               N_TABLES  = 6,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h7F,
    parameter logic [DATA_W-1:0] SEL_RESET = 8'h01,
    localparam int IDX_W = (N_TABLES > 1) ? $clog2(N_TABLES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  addr_dec_t         dec,
    input  logic              tbl_valid,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] sel
);

    localparam logic [OFF_W-1:0] SEL_OFF = SEL_ADDR[OFF_W-1:0];

    logic [DATA_W-1:0] lo_mem [HALF_DEPTH];
    logic [DATA_W-1:0] tbl_rd [N_TABLES];
    logic [DATA_W-1:0] rd_next;

    // Always-mapped bank
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HALF_DEPTH; i++)
                lo_mem[i] <= (OFF_W'(i) == SEL_OFF) ? SEL_RESET : '0;
        end else if (acc.lo_we) begin
            lo_mem[dec.offset] <= wdata;
        end
    end

    assign sel = lo_mem[SEL_OFF];

    // One storage page per selector value
    for (genvar t = 0; t < N_TABLES; t++) begin : g_tbl
        logic [DATA_W-1:0] mem [HALF_DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < HALF_DEPTH; i++)
                    mem[i] <= '0;
            end else if (acc.up_we && (tbl_idx == IDX_W'(t))) begin
                mem[dec.offset] <= wdata;
            end
        end

        assign tbl_rd[t] = mem[dec.offset];
    end

    always_comb begin
        if (!dec.upper)
            rd_next = lo_mem[dec.offset];
        else if (tbl_valid)
            rd_next = tbl_rd[tbl_idx];
        else
            rd_next = '1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (acc.rd_en)
            rdata <= rd_next;
    end

endmodule

// File: rtl/regpage_map.sv
module regpage_map
    import regpage_pkg::*;
#(
    parameter int                N_TABLES  = 6,
    parameter logic [ADDR_W-1:0] SEL_ADDR  = 8'h7F,
    parameter logic [DATA_W-1:0] SEL_RESET = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pw1_ok,
    input  logic              pw2_ok,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_denied
);

    localparam int IDX_W = (N_TABLES > 1) ? $clog2(N_TABLES) : 1;

    addr_dec_t         dec;
    access_t           acc;
    logic              tbl_valid;
    logic [IDX_W-1:0]  tbl_idx;
    logic [DATA_W-1:0] sel_q;

    regpage_decode #(.N_TABLES(N_TABLES)) u_dec (
        .addr      (addr),
        .sel       (sel_q),
        .dec       (dec),
        .tbl_valid (tbl_valid),
        .tbl_idx   (tbl_idx)
    );

    regpage_gate u_gate (
        .req       (req),
        .we        (we),
        .dec       (dec),
        .tbl_valid (tbl_valid),
        .sel       (sel_q),
        .pw1_ok    (pw1_ok),
        .pw2_ok    (pw2_ok),
        .acc       (acc)
    );

    regpage_store #(
        .N_TABLES  (N_TABLES),
        .SEL_ADDR  (SEL_ADDR),
        .SEL_RESET (SEL_RESET)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .dec       (dec),
        .tbl_valid (tbl_valid),
        .tbl_idx   (tbl_idx),
        .wdata     (wdata),
        .rdata     (rdata),
        .sel       (sel_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            wr_denied <= 1'b0;
        else if (acc.deny)
            wr_denied <= 1'b1;
    end

endmodule

// File: rtl/regpage_map_chk.sv
module regpage_map_chk #(
    parameter int         N_TABLES  = 6,
    parameter logic [7:0] SEL_RESET = 8'h01
) (
    input logic       clk,
    input logic       rst,
    input logic       req,
    input logic       we,
    input logic [7:0] addr,
    input logic       pw1_ok,
    input logic       pw2_ok,
    input logic [7:0] rdata,
    input logic       wr_denied,
    input logic [7:0] sel
);

    logic sel_undef;
    assign sel_undef = (sel == 8'h00) || (sel > 8'(N_TABLES));

    p_lower_nodeny_r1: assert property (@(posedge clk) disable iff (rst)
        (req && we && !addr[7] && !wr_denied) |=> !wr_denied);

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(req && !we) |=> $stable(rdata));

    p_sel_reset_r3: assert property (@(posedge clk)
        $fell(rst) |-> (sel == SEL_RESET));

    p_deny_l1_r5: assert property (@(posedge clk) disable iff (rst)
        (req && we && addr[7] && sel == 8'h01 && !pw1_ok && !pw2_ok) |=> wr_denied);

    p_deny_l2_r6: assert property (@(posedge clk) disable iff (rst)
        (req && we && addr[7] && sel >= 8'h02 && sel <= 8'h05 && !pw2_ok) |=> wr_denied);

    p_deny_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        wr_denied |=> wr_denied);

    p_undef_ff_r9: assert property (@(posedge clk) disable iff (rst)
        (req && !we && addr[7] && sel_undef) |=> (rdata == 8'hFF));

    p_undef_nodeny_r9: assert property (@(posedge clk) disable iff (rst)
        (req && we && addr[7] && sel_undef && !wr_denied) |=> !wr_denied);

endmodule

bind regpage_map regpage_map_chk #(
    .N_TABLES  (N_TABLES),
    .SEL_RESET (SEL_RESET)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .we        (we),
    .addr      (addr),
    .pw1_ok    (pw1_ok),
    .pw2_ok    (pw2_ok),
    .rdata     (rdata),
    .wr_denied (wr_denied),
    .sel       (sel_q)
);

// File: tb/regpage_map_tb.sv
module regpage_map_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       pw1_ok = 1'b0;
    logic       pw2_ok = 1'b0;
    logic [7:0] rdata;
    logic       wr_denied;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    regpage_map u_dut (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .pw1_ok    (pw1_ok),
        .pw2_ok    (pw2_ok),
        .rdata     (rdata),
        .wr_denied (wr_denied)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic p1, input logic p2);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d; pw1_ok = p1; pw2_ok = p2;
        @(negedge clk);
        req = 1'b0; we = 1'b0; pw1_ok = 1'b0; pw2_ok = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        do_reset();
        check("R10 rdata after reset", rdata, 8'h00);
        check("R10 wr_denied after reset", {7'd0, wr_denied}, 8'h00);
        rd(8'h7F, v); check("R3 selector reset value", v, 8'h01);
        rd(8'h22, v); check("R10 lower byte cleared", v, 8'h00);
        rd(8'hC4, v); check("R10 page byte cleared", v, 8'h00);
    endtask

    task automatic t_lower();
        logic [7:0] v;
        do_reset();
        wr(8'h10, 8'hA5, 1'b0, 1'b0);
        rd(8'h10, v); check("R1 lower write no grant", v, 8'hA5);
        wr(8'h7F, 8'h00, 1'b0, 1'b0);
        wr(8'h11, 8'h3C, 1'b0, 1'b0);
        rd(8'h11, v); check("R1 lower write undefined selector", v, 8'h3C);
        check("R1 no refusal from lower writes", {7'd0, wr_denied}, 8'h00);
    endtask

    task automatic t_rdata_hold();
        logic [7:0] v;
        do_reset();
        wr(8'h05, 8'h77, 1'b0, 1'b0);
        rd(8'h05, v);
        repeat (3) @(negedge clk);
        check("R2 rdata holds when idle", rdata, 8'h77);
        wr(8'h05, 8'h12, 1'b0, 1'b0);
        check("R2 rdata holds over write", rdata, 8'h77);
    endtask

    task automatic t_page1();
        logic [7:0] v;
        do_reset();
        wr(8'h80, 8'h11, 1'b0, 1'b0);
        rd(8'h80, v); check("R5 no grant write refused", v, 8'h00);
        check("R8 refusal flag set", {7'd0, wr_denied}, 8'h01);
        wr(8'h80, 8'h21, 1'b1, 1'b0);
        rd(8'h80, v); check("R5 first-level write", v, 8'h21);
        wr(8'h81, 8'h22, 1'b0, 1'b1);
        rd(8'h81, v); check("R5 second-level covers first", v, 8'h22);
        check("R8 flag stays high", {7'd0, wr_denied}, 8'h01);
        do_reset();
        check("R8 flag cleared by reset", {7'd0, wr_denied}, 8'h00);
    endtask

    task automatic t_level2();
        logic [7:0] v;
        for (int t = 2; t <= 5; t++) begin
            do_reset();
            wr(8'h7F, 8'(t), 1'b0, 1'b0);
            wr(8'h90, 8'h40 + 8'(t), 1'b1, 1'b0);
            rd(8'h90, v); check("R6 first-level alone refused", v, 8'h00);
            check("R8 refusal flag on page", {7'd0, wr_denied}, 8'h01);
            wr(8'h90, 8'h50 + 8'(t), 1'b0, 1'b1);
            rd(8'h90, v); check("R6 second-level write", v, 8'h50 + 8'(t));
        end
    endtask

    task automatic t_open_page();
        logic [7:0] v;
        do_reset();
        wr(8'h7F, 8'h06, 1'b0, 1'b0);
        wr(8'hFF, 8'h66, 1'b0, 1'b0);
        rd(8'hFF, v); check("R7 open page write", v, 8'h66);
        check("R7 open page no refusal", {7'd0, wr_denied}, 8'h00);
    endtask

    task automatic t_distinct();
        logic [7:0] v;
        do_reset();
        for (int t = 1; t <= 6; t++) begin
            wr(8'h7F, 8'(t), 1'b0, 1'b0);
            wr(8'h85, 8'hB0 + 8'(t), 1'b0, 1'b1);
        end
        for (int t = 1; t <= 6; t++) begin
            wr(8'h7F, 8'(t), 1'b0, 1'b0);
            rd(8'h85, v); check("R4 page keeps own byte", v, 8'hB0 + 8'(t));
        end
        wr(8'h7F, 8'h02, 1'b0, 1'b0);
        rd(8'h85, v); check("R3 selector change applies next access", v, 8'hB2);
        rd(8'h05, v); check("R4 lower bank not aliased", v, 8'h00);
    endtask

    task automatic t_undefined();
        logic [7:0] v;
        do_reset();
        wr(8'h7F, 8'h00, 1'b0, 1'b0);
        rd(8'h80, v); check("R9 selector 00 reads FF", v, 8'hFF);
        wr(8'h80, 8'h99, 1'b1, 1'b1);
        check("R9 undefined write no refusal", {7'd0, wr_denied}, 8'h00);
        wr(8'h7F, 8'h07, 1'b0, 1'b0);
        rd(8'hA0, v); check("R9 selector 07 reads FF", v, 8'hFF);
        wr(8'hA0, 8'h98, 1'b0, 1'b0);
        wr(8'h7F, 8'hFF, 1'b0, 1'b0);
        rd(8'hA0, v); check("R9 selector FF reads FF", v, 8'hFF);
        for (int t = 1; t <= 6; t++) begin
            wr(8'h7F, 8'(t), 1'b0, 1'b0);
            rd(8'h80, v); check("R9 pages untouched offset 00", v, 8'h00);
            rd(8'hA0, v); check("R9 pages untouched offset 20", v, 8'h00);
        end
        check("R9 flag still low", {7'd0, wr_denied}, 8'h00);
    endtask

    task automatic t_read_ungated();
        logic [7:0] v;
        do_reset();
        wr(8'h7F, 8'h03, 1'b0, 1'b0);
        wr(8'hB3, 8'h5A, 1'b0, 1'b1);
        rd(8'hB3, v); check("R11 read without grant", v, 8'h5A);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_lower();
        t_rdata_hold();
        t_page1();
        t_level2();
        t_open_page();
        t_distinct();
        t_undefined();
        t_read_ungated();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule